// File: doc/BRIEF.md
# Bypass-Capable Router Input Unit

This unit sits at one straight-path input of a source-routed router whose links follow two ordered chains. Each valid flit that arrives is offered at once on a combinational bypass toward the output stage. In the same cycle it is copied into a small local backup buffer. If the output stage takes the bypassed flit in that cycle, the backup copy is marked for discard and leaves the buffer without producing a write. If the output stage does not take it, the copy is committed to the queue that matches its direction. That queue is the straight queue, the turn queue or the local queue.

Head flits carry a per-hop route field. The unit decodes the two leading bits of that field as the direction at this node. It then shifts the field left by two places before the flit leaves, so that the next router finds its own code in the same position. Body and tail flits take the direction of their head. A packet that turns or ends here never uses the bypass. A packet whose head carries the reserved code is dropped whole and raises a one-cycle error flag. Once any flit of a packet misses the bypass, the rest of that packet goes through the queues, which keeps packets from interleaving.

Top module: `rtr_input_unit`

## Requirements
- R1: Flit layout, from the MSB down: bit FLIT_W-1 is the valid bit. The next two bits are the type: 00 single-flit packet, 01 head, 10 body, 11 tail. In head and single flits the next two bits are the direction at this node: 00 straight, 01 turn, 10 local, 11 reserved. `cur_dir` reports the direction of the flit now on the input.
- R2: A head or single flit leaves with its ROUTE_W-bit route field shifted left by two and zero-filled. Its valid, type and payload bits are unchanged. Body and tail flits leave bit-for-bit unchanged, on the bypass and in the queue alike.
- R3: A valid straight flit is offered on `byp_valid` in its arrival cycle with no register on the path. This requires `congested` low, no committed entry waiting in the backup buffer, and (for body and tail flits) the packet still on the bypass.
- R4: When `byp_valid` and `byp_accept` are both high, the backup copy of that flit is discarded and produces no queue write.
- R5: A flit that is not taken on the bypass is written to its queue. With the buffer empty and `q_full` low, it appears on `q_wr_en`/`q_wr_flit`/`q_wr_dir` (dir 00 for straight) in the cycle after it arrives.
- R6: Turn (01) and local (10) flits never raise `byp_valid`. They are written to the queue with `q_wr_dir` equal to their code.
- R7: Body and tail flits use the direction latched from their packet's head, whatever bits they carry in the route position, until the tail has passed.
- R8: After a flit of a packet misses the bypass, no later flit of that packet is offered on the bypass, even when the buffer has drained.
- R9: A head with the reserved code pulses `route_err` for one cycle, in the cycle after the head. That head and every later flit of its packet, up to and including the tail, produce neither a bypass offer nor a queue write.
- R10: While a committed entry is still in the backup buffer, no new flit is offered on the bypass, so queued flits keep their order ahead of newer ones.
- R11: While `q_full` is high, `q_wr_en` stays low and entries stay in the buffer in arrival order. `up_off` is high whenever the buffer holds OFF_LEVEL or more entries.
- R12: During and right after a synchronous active-low reset, the buffer is empty and `q_wr_en`, `route_err` and `up_off` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the incoming link |
| rst_n | input | 1 | Synchronous active-low reset |
| in_flit | input | FLIT_W | Incoming flit; its MSB is the valid bit |
| byp_accept | input | 1 | Output stage takes the bypass flit this cycle |
| congested | input | 1 | Older packets are waiting for the output port |
| q_full | input | 1 | Target queue cannot take a write this cycle |
| byp_valid | output | 1 | Bypass flit offered |
| byp_flit | output | FLIT_W | Bypass flit with the route field shifted |
| cur_dir | output | 2 | Direction of the flit now on the input |
| q_wr_en | output | 1 | Queue write strobe |
| q_wr_dir | output | 2 | Queue selected for the write |
| q_wr_flit | output | FLIT_W | Flit written to the queue |
| route_err | output | 1 | One-cycle pulse for a reserved route code |
| up_off | output | 1 | Off indication to the upstream node |

## Verification
The bench builds the unit with a 20-bit flit, a 6-bit route field, a four-entry backup buffer and an off level of three. With these values, three stalled flits are enough to raise the off indication, and the buffer still has room to show drain order. A short route field makes every shifted head easy to predict. The body flits used in the bypass run carry ones in the route position, so a design that decodes body bits instead of the latched head direction shows up at once. The packet that misses the bypass is given an idle gap after the miss, so the buffer is empty again. This separates the per-packet rule from the pending-entry rule.

// File: rtl/rtr_in_pkg.sv
// Shared encodings for the router input unit.
// Assumes a flit whose MSB is valid, followed by a 2-bit type and a route field.
package rtr_in_pkg;
    localparam logic [1:0] DIR_STRAIGHT = 2'b00;
    localparam logic [1:0] DIR_TURN     = 2'b01;
    localparam logic [1:0] DIR_LOCAL    = 2'b10;
    localparam logic [1:0] DIR_RSVD     = 2'b11;

    localparam logic [1:0] FT_SINGLE = 2'b00;
    localparam logic [1:0] FT_HEAD   = 2'b01;
    localparam logic [1:0] FT_BODY   = 2'b10;
    localparam logic [1:0] FT_TAIL   = 2'b11;
endpackage

// File: rtl/rtr_route_decode.sv
// Combinational flit decode: valid bit, type class, head direction, and the
// outgoing flit with the route field advanced by one hop.
// Assumes ROUTE_W >= 2 and at least one payload bit below the route field.
module rtr_route_decode
    import rtr_in_pkg::*;
#(
    parameter int FLIT_W  = 24,
    parameter int ROUTE_W = 8
) (
    input  logic [FLIT_W-1:0] flit,
    output logic              present,
    output logic              is_head,
    output logic              is_tail,
    output logic [1:0]        hdr_dir,
    output logic [FLIT_W-1:0] fwd_flit
);
    localparam int PAY_W = FLIT_W - 3 - ROUTE_W;

    logic [1:0]         ftype;
    logic [ROUTE_W-1:0] route;
    logic [ROUTE_W-1:0] route_next;

    // Field extraction by fixed position.
    always_comb begin
        present = flit[FLIT_W-1];
        ftype   = flit[FLIT_W-2 -: 2];
        route   = flit[FLIT_W-4 -: ROUTE_W];
        hdr_dir = route[ROUTE_W-1 -: 2];
        is_head = (ftype == FT_HEAD) || (ftype == FT_SINGLE);
        is_tail = (ftype == FT_TAIL) || (ftype == FT_SINGLE);
    end

    // Hop shift: pure wiring, the consumed code drops off the top.
    generate
        if (ROUTE_W > 2) begin : g_shift
            assign route_next = {route[ROUTE_W-3:0], 2'b00};
        end else begin : g_last
            assign route_next = '0;
        end
    endgenerate

    // Only head-class flits carry a route field to advance.
    always_comb begin
        if (is_head)
            fwd_flit = {flit[FLIT_W-1 -: 3], route_next, flit[PAY_W-1:0]};
        else
            fwd_flit = flit;
    end
endmodule

// File: rtl/rtr_pkt_track.sv
// Per-packet state: the direction latched from the head, whether the packet
// is still on the bypass, whether it is being dropped, and the error pulse.
// Assumes flits of one packet arrive contiguously (wormhole order).
module rtr_pkt_track
    import rtr_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       present,
    input  logic       is_head,
    input  logic       is_tail,
    input  logic [1:0] hdr_dir,
    input  logic       byp_taken,
    output logic [1:0] cur_dir,
    output logic       drop_cur,
    output logic       on_byp,
    output logic       err_pulse
);
    logic [1:0] lat_dir;
    logic       drop_q;
    logic       byp_q;

    // Current flit's view: a head decides afresh, others inherit.
    always_comb begin
        if (is_head) begin
            cur_dir  = hdr_dir;
            drop_cur = (hdr_dir == DIR_RSVD);
            on_byp   = 1'b1;
        end else begin
            cur_dir  = lat_dir;
            drop_cur = drop_q;
            on_byp   = byp_q;
        end
    end

    // Carry packet state forward until the tail passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_dir   <= DIR_STRAIGHT;
            drop_q    <= 1'b0;
            byp_q     <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= present && is_head && (hdr_dir == DIR_RSVD);
            if (present) begin
                lat_dir <= cur_dir;
                drop_q  <= drop_cur && !is_tail;
                byp_q   <= on_byp && byp_taken && !is_tail;
            end
        end
    end
endmodule

// File: rtl/rtr_backup_fifo.sv
// Small synchronous backup buffer written in the incoming clock domain.
// Assumes the caller never pushes while full without popping.
module rtr_backup_fifo #(
    parameter int DATA_W = 27,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic [DATA_W-1:0]            head_data,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    // Status and read port.
    always_comb begin
        empty     = (count == '0);
        full      = (count == FULL_CNT);
        do_push   = push && !full;
        do_pop    = pop && !empty;
        head_data = mem[rd_ptr];
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rtr_input_unit.sv
// Straight-path input unit: offers each flit on a zero-latch bypass while
// keeping a backup copy, then discards or commits that copy to a queue.
// Assumes the output stage answers byp_accept in the same cycle as byp_valid.
module rtr_input_unit
    import rtr_in_pkg::*;
#(
    parameter int FLIT_W    = 24,
    parameter int ROUTE_W   = 8,
    parameter int DEPTH     = 4,
    parameter int OFF_LEVEL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              byp_accept,
    input  logic              congested,
    input  logic              q_full,
    output logic              byp_valid,
    output logic [FLIT_W-1:0] byp_flit,
    output logic [1:0]        cur_dir,
    output logic              q_wr_en,
    output logic [1:0]        q_wr_dir,
    output logic [FLIT_W-1:0] q_wr_flit,
    output logic              route_err,
    output logic              up_off
);
    localparam int ENT_W = FLIT_W + 3;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] OFF_CNT = CNT_W'(OFF_LEVEL);

    logic              present;
    logic              is_head;
    logic              is_tail;
    logic [1:0]        hdr_dir;
    logic [FLIT_W-1:0] fwd_flit;
    logic              drop_cur;
    logic              pkt_on_byp;
    logic              byp_taken;
    logic              push;
    logic [ENT_W-1:0]  push_data;
    logic              pop;
    logic [ENT_W-1:0]  head_data;
    logic              head_commit;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CNT_W-1:0]  fifo_count;
    logic [CNT_W-1:0]  pend_cnt;

    rtr_route_decode #(.FLIT_W(FLIT_W), .ROUTE_W(ROUTE_W)) u_dec (
        .flit     (in_flit),
        .present  (present),
        .is_head  (is_head),
        .is_tail  (is_tail),
        .hdr_dir  (hdr_dir),
        .fwd_flit (fwd_flit)
    );

    rtr_pkt_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .present   (present),
        .is_head   (is_head),
        .is_tail   (is_tail),
        .hdr_dir   (hdr_dir),
        .byp_taken (byp_taken),
        .cur_dir   (cur_dir),
        .drop_cur  (drop_cur),
        .on_byp    (pkt_on_byp),
        .err_pulse (route_err)
    );

    rtr_backup_fifo #(.DATA_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head_data (head_data),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    // Bypass offer and outcome for the flit now on the input.
    always_comb begin
        byp_valid = present && !drop_cur && (cur_dir == DIR_STRAIGHT)
                    && !congested && (pend_cnt == '0) && pkt_on_byp;
        byp_flit  = fwd_flit;
        byp_taken = byp_valid && byp_accept;
    end

    // Backup write: every kept flit, tagged with its fate.
    always_comb begin
        push      = present && !drop_cur && !fifo_full;
        push_data = {!byp_taken, cur_dir, fwd_flit};
    end

    // Drain: discarded copies leave silently, committed ones wait for room.
    always_comb begin
        head_commit = head_data[ENT_W-1];
        pop         = !fifo_empty && (!head_commit || !q_full);
        q_wr_en     = !fifo_empty && head_commit && !q_full;
        q_wr_dir    = head_data[FLIT_W+1:FLIT_W];
        q_wr_flit   = head_data[FLIT_W-1:0];
        up_off      = (fifo_count >= OFF_CNT);
    end

    // Count committed entries still waiting, to hold order behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt <= '0;
        end else begin
            case ({push && !byp_taken, q_wr_en})
                2'b10:   pend_cnt <= pend_cnt + 1'b1;
                2'b01:   pend_cnt <= pend_cnt - 1'b1;
                default: pend_cnt <= pend_cnt;
            endcase
        end
    end
endmodule

// File: rtl/rtr_input_unit_chk.sv
// Temporal checks on the input unit, attached by bind.
module rtr_input_unit_chk #(
    parameter int FLIT_W    = 24,
    parameter int DEPTH     = 4,
    parameter int OFF_LEVEL = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [FLIT_W-1:0]          in_flit,
    input logic                       byp_valid,
    input logic                       byp_accept,
    input logic                       congested,
    input logic                       q_full,
    input logic [1:0]                 cur_dir,
    input logic                       q_wr_en,
    input logic                       route_err,
    input logic                       up_off,
    input logic                       fifo_empty,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);
    localparam int CNT_W = $clog2(DEPTH+1);

    // R3
    byp_uncongested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_valid |-> !congested);

    // R6
    byp_straight_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_valid |-> (cur_dir == 2'b00));

    // R4
    flushed_copy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_valid && byp_accept && fifo_empty) |=> !q_wr_en);

    // R9
    err_after_reserved_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |-> $past(in_flit[FLIT_W-1] && !in_flit[FLIT_W-2]
                            && (in_flit[FLIT_W-4 -: 2] == 2'b11)));

    // R11
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !q_wr_en);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_wr_en && !route_err && !up_off));
endmodule

bind rtr_input_unit rtr_input_unit_chk #(
    .FLIT_W    (FLIT_W),
    .DEPTH     (DEPTH),
    .OFF_LEVEL (OFF_LEVEL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_flit    (in_flit),
    .byp_valid  (byp_valid),
    .byp_accept (byp_accept),
    .congested  (congested),
    .q_full     (q_full),
    .cur_dir    (cur_dir),
    .q_wr_en    (q_wr_en),
    .route_err  (route_err),
    .up_off     (up_off),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count)
);

// File: tb/rtr_input_unit_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module rtr_input_unit_bench;
    localparam int FW = 20;
    localparam int RW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] in_flit = '0;
    logic          byp_accept = 1'b0;
    logic          congested = 1'b0;
    logic          q_full = 1'b0;
    logic          byp_valid;
    logic [FW-1:0] byp_flit;
    logic [1:0]    cur_dir;
    logic          q_wr_en;
    logic [1:0]    q_wr_dir;
    logic [FW-1:0] q_wr_flit;
    logic          route_err;
    logic          up_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtr_input_unit #(.FLIT_W(FW), .ROUTE_W(RW), .DEPTH(4), .OFF_LEVEL(3)) u_rtr_input_unit (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .byp_accept(byp_accept),
        .congested(congested), .q_full(q_full), .byp_valid(byp_valid),
        .byp_flit(byp_flit), .cur_dir(cur_dir), .q_wr_en(q_wr_en),
        .q_wr_dir(q_wr_dir), .q_wr_flit(q_wr_flit), .route_err(route_err),
        .up_off(up_off)
    );

    function automatic logic [FW-1:0] mk(input logic [1:0] ft, input logic [5:0] rt,
                                         input logic [10:0] pay);
        return {1'b1, ft, rt, pay};
    endfunction

    // Expected head after one hop: route advanced by two, zero fill.
    function automatic logic [FW-1:0] shf(input logic [FW-1:0] f);
        return {f[19:17], f[14:11], 2'b00, f[10:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [FW-1:0] f, input logic acc, input logic cg,
                         input logic qf);
        @(negedge clk);
        in_flit = f; byp_accept = acc; congested = cg; q_full = qf;
        #1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive('0, 0, 0, 0);
        chk("R12 q_wr_en", q_wr_en, 0);
        chk("R12 up_off", up_off, 0);
        chk("R12 route_err", route_err, 0);
        chk("R12 byp_valid", byp_valid, 0);
    endtask

    task automatic t_bypass();
        logic [FW-1:0] h = mk(2'b01, 6'b00_01_10, 11'h0A1);
        logic [FW-1:0] b = mk(2'b10, 6'b111111, 11'h0A2);
        logic [FW-1:0] t = mk(2'b11, 6'b000000, 11'h0A3);
        drive(h, 1, 0, 0);
        chk("R3 head offered", byp_valid, 1);
        chk("R2 head shifted", byp_flit, shf(h));
        chk("R1 head dir straight", cur_dir, 0);
        drive(b, 1, 0, 0);
        chk("R7 body keeps head dir", cur_dir, 0);
        chk("R3 body offered", byp_valid, 1);
        chk("R2 body unchanged", byp_flit, b);
        chk("R4 head copy flushed", q_wr_en, 0);
        drive(t, 1, 0, 0);
        chk("R3 tail offered", byp_valid, 1);
        chk("R4 body copy flushed", q_wr_en, 0);
        drive('0, 0, 0, 0);
        chk("R4 tail copy flushed", q_wr_en, 0);
    endtask

    task automatic t_refused();
        logic [FW-1:0] s = mk(2'b00, 6'b00_10_00, 11'h0B1);
        drive(s, 0, 0, 0);
        chk("R3 single offered", byp_valid, 1);
        drive('0, 0, 0, 0);
        chk("R5 refused written", q_wr_en, 1);
        chk("R5 straight queue", q_wr_dir, 0);
        chk("R5 queued flit", q_wr_flit, shf(s));
        drive('0, 0, 0, 0);
        chk("R5 single write only", q_wr_en, 0);
    endtask

    task automatic t_congested();
        logic [FW-1:0] h = mk(2'b01, 6'b00_00_10, 11'h0C1);
        logic [FW-1:0] b = mk(2'b10, 6'b000000, 11'h0C2);
        logic [FW-1:0] t = mk(2'b11, 6'b000000, 11'h0C3);
        drive(h, 1, 1, 0);
        chk("R5 congested not offered", byp_valid, 0);
        drive('0, 0, 0, 0);
        chk("R5 congested head queued", q_wr_en, 1);
        chk("R5 congested head flit", q_wr_flit, shf(h));
        drive(b, 1, 0, 0);
        chk("R8 body stays queued", byp_valid, 0);
        chk("R8 buffer drained", q_wr_en, 0);
        drive(t, 1, 0, 0);
        chk("R8 tail stays queued", byp_valid, 0);
        chk("R5 body queued", q_wr_flit, b);
        drive('0, 0, 0, 0);
        chk("R5 tail queued", q_wr_en, 1);
        chk("R5 tail flit", q_wr_flit, t);
        drive('0, 0, 0, 0);
    endtask

    task automatic t_midmiss();
        logic [FW-1:0] h = mk(2'b01, 6'b00_11_00, 11'h0D1);
        logic [FW-1:0] b = mk(2'b10, 6'b000000, 11'h0D2);
        logic [FW-1:0] t = mk(2'b11, 6'b000000, 11'h0D3);
        drive(h, 1, 0, 0);
        chk("R3 head offered", byp_valid, 1);
        drive(b, 0, 0, 0);
        chk("R3 body offered", byp_valid, 1);
        drive('0, 0, 0, 0);
        chk("R5 missed body queued", q_wr_en, 1);
        chk("R5 missed body flit", q_wr_flit, b);
        drive(t, 1, 0, 0);
        chk("R8 tail after miss", byp_valid, 0);
        drive('0, 0, 0, 0);
        chk("R8 tail queued", q_wr_flit, t);
        drive('0, 0, 0, 0);
    endtask

    task automatic t_turn_local();
        logic [FW-1:0] h = mk(2'b01, 6'b01_10_00, 11'h0E1);
        logic [FW-1:0] t = mk(2'b11, 6'b000000, 11'h0E2);
        logic [FW-1:0] l = mk(2'b00, 6'b10_00_00, 11'h0E5);
        drive(h, 1, 0, 0);
        chk("R6 turn not offered", byp_valid, 0);
        chk("R1 turn dir", cur_dir, 1);
        drive(t, 1, 0, 0);
        chk("R7 tail follows turn", cur_dir, 1);
        chk("R6 turn tail not offered", byp_valid, 0);
        chk("R6 turn head to turn queue", q_wr_dir, 1);
        chk("R6 turn head flit", q_wr_flit, shf(h));
        drive('0, 0, 0, 0);
        chk("R6 turn tail queued", q_wr_flit, t);
        drive(l, 1, 0, 0);
        chk("R6 local not offered", byp_valid, 0);
        chk("R1 local dir", cur_dir, 2);
        drive('0, 0, 0, 0);
        chk("R6 local queue", q_wr_dir, 2);
        chk("R6 local flit", q_wr_flit, shf(l));
        drive('0, 0, 0, 0);
    endtask

    task automatic t_reserved();
        logic [FW-1:0] h = mk(2'b01, 6'b11_00_00, 11'h0F1);
        logic [FW-1:0] b = mk(2'b10, 6'b000000, 11'h0F2);
        logic [FW-1:0] t = mk(2'b11, 6'b000000, 11'h0F3);
        logic [FW-1:0] s = mk(2'b00, 6'b00_00_00, 11'h0F4);
        drive(h, 1, 0, 0);
        chk("R9 reserved head not offered", byp_valid, 0);
        drive(b, 1, 0, 0);
        chk("R9 error pulse", route_err, 1);
        chk("R9 dropped body not offered", byp_valid, 0);
        chk("R9 head not queued", q_wr_en, 0);
        drive(t, 1, 0, 0);
        chk("R9 pulse one cycle", route_err, 0);
        chk("R9 dropped tail not offered", byp_valid, 0);
        chk("R9 body not queued", q_wr_en, 0);
        drive(s, 1, 0, 0);
        chk("R9 tail not queued", q_wr_en, 0);
        chk("R9 drop ends at tail", byp_valid, 1);
        drive('0, 0, 0, 0);
    endtask

    task automatic t_stall();
        logic [FW-1:0] s1 = mk(2'b00, 6'b00_01_01, 11'h101);
        logic [FW-1:0] s2 = mk(2'b00, 6'b00_01_01, 11'h102);
        logic [FW-1:0] s3 = mk(2'b00, 6'b00_01_01, 11'h103);
        drive(s1, 0, 0, 1);
        chk("R3 first offered", byp_valid, 1);
        drive(s2, 1, 0, 1);
        chk("R10 blocked behind pending", byp_valid, 0);
        chk("R11 stalled", q_wr_en, 0);
        drive(s3, 1, 0, 1);
        chk("R11 below off level", up_off, 0);
        drive('0, 0, 0, 1);
        chk("R11 off at level", up_off, 1);
        chk("R11 still stalled", q_wr_en, 0);
        drive('0, 0, 0, 0);
        chk("R11 drain first", q_wr_flit, shf(s1));
        chk("R11 drain write", q_wr_en, 1);
        drive('0, 0, 0, 0);
        chk("R11 drain second", q_wr_flit, shf(s2));
        chk("R11 off released", up_off, 0);
        drive('0, 0, 0, 0);
        chk("R11 drain third", q_wr_flit, shf(s3));
        drive('0, 0, 0, 0);
        chk("R11 drained", q_wr_en, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_refused();
        t_congested();
        t_midmiss();
        t_turn_local();
        t_reserved();
        t_stall();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule